// File: doc/BRIEF.md
# Power Control Register with Reset-Type Flag

This block is one byte-wide special-function register for a microcontroller core. It holds the bits that put the core into its low-power states, idle and power-down. It also holds two serial-port configuration bits and two free software flags. One flag records what kind of reset came last. Software reaches the register over a simple SFR bus. The bus has an address, a write enable, write data and a combinational read-data return. The register answers at one fixed address, and each write replaces the whole byte.

The reset-type flag is the reason for the block. Only the power-on reset sets it, and the warm reset leaves it as it was. Software clears the flag once after start-up. After any later reset, it can tell a supply power-up (flag is 1) from a warm restart (flag is still 0). The idle bit is also cleared by hardware whenever an interrupt is pending. This is how an interrupt brings the core out of idle. Both resets clear the idle and power-down bits. The four mode bits drive the block's output pins directly.

Top module: `pwr_mode_reg`

## Requirements
- R1: The register decodes only SFR address 0x87 (parameter `REG_ADDR`). A write with any other address leaves the register unchanged. A read with any other address returns 0x00.
- R2: A write to 0x87 stores the whole byte. Bit 7 is baud doubling, bit 6 is frame select, bit 4 is the reset-type flag, bit 3 is general flag 1, bit 2 is general flag 0, bit 1 is power-down and bit 0 is idle.
- R3: A power-on reset loads 0x10: the reset-type flag is 1 and every other bit is 0.
- R4: A warm reset clears bits 7, 6, 3, 2, 1 and 0, and keeps the reset-type flag at whatever value it had.
- R5: Software writes can both set and clear the reset-type flag (bit 4).
- R6: Bit 5 is reserved. It ignores writes and always reads back 0.
- R7: When the interrupt-pending input is high in a cycle, bit 0 (idle) is 0 after that clock edge. The other bits are unaffected.
- R8: If an interrupt is pending in the same cycle as a write that sets bit 0, bit 0 ends up 0. The other written bits still take effect.
- R9: `idleMode`, `pdMode`, `baudDouble` and `frameSel` always equal register bits 0, 1, 7 and 6.
- R10: A reset takes precedence over a write in the same cycle. Power-on reset takes precedence over warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, synchronous, active high |
| warmRst | input | 1 | Warm reset, synchronous, active high |
| sfrAddr | input | 8 | SFR bus address |
| sfrWe | input | 1 | SFR write enable |
| sfrWdata | input | 8 | SFR write data |
| sfrRdata | output | 8 | SFR read data, combinational, 0 when the address misses |
| irqPending | input | 1 | An interrupt is pending; clears the idle bit |
| idleMode | output | 1 | Idle mode request (bit 0) |
| pdMode | output | 1 | Power-down mode request (bit 1) |
| baudDouble | output | 1 | Serial baud-rate doubling (bit 7) |
| frameSel | output | 1 | Serial framing-select (bit 6) |

## Verification
The assertions take all inputs as synchronous to `clk`. They take the resets to be held for whole cycles, and they judge each register update against the inputs of the one cycle before. The stimulus changes inputs only on the falling edge. It holds each reset, write or interrupt for exactly one rising edge, and returns the bus to idle between operations. It sweeps every byte value through the write path and every address other than the decoded one. It also collides writes with interrupts and with both resets.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam int BIT_IDL   = 0;
  localparam int BIT_PD    = 1;
  localparam int BIT_GF0   = 2;
  localparam int BIT_GF1   = 3;
  localparam int BIT_POF   = 4;
  localparam int BIT_RSV   = 5;
  localparam int BIT_FRAME = 6;
  localparam int BIT_BAUD  = 7;

  localparam logic [DATA_W-1:0] COLD_VALUE = DATA_W'(1) << BIT_POF;

  typedef struct packed {
    logic porLoad;
    logic warmLoad;
    logic swWrite;
    logic irqClear;
  } pwrStrobe_t;
endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              warmRst,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic              irqPending,
  output logic              addrHit,
  output pwrStrobe_t        strobe
);
  logic anyReset;

  always_comb begin
    addrHit         = (sfrAddr == REG_ADDR);
    anyReset        = porRst | warmRst;
    strobe.porLoad  = porRst;
    strobe.warmLoad = warmRst & ~porRst;
    strobe.swWrite  = sfrWe & addrHit & ~anyReset;
    strobe.irqClear = irqPending & ~anyReset;
  end

  // R10: a reset and a software load are never issued together
  assert_reset_blocks_write_R10: assert property (@(posedge clk)
    (porRst || warmRst) |-> !strobe.swWrite);
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  pwrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] regVal
);
  logic baudQ, frameQ, pofQ, gf1Q, gf0Q, pdQ, idlQ;

  always_ff @(posedge clk) begin
    if (strobe.porLoad) begin
      baudQ  <= COLD_VALUE[BIT_BAUD];
      frameQ <= COLD_VALUE[BIT_FRAME];
      pofQ   <= COLD_VALUE[BIT_POF];
      gf1Q   <= COLD_VALUE[BIT_GF1];
      gf0Q   <= COLD_VALUE[BIT_GF0];
      pdQ    <= COLD_VALUE[BIT_PD];
      idlQ   <= COLD_VALUE[BIT_IDL];
    end else if (strobe.warmLoad) begin
      baudQ  <= 1'b0;
      frameQ <= 1'b0;
      gf1Q   <= 1'b0;
      gf0Q   <= 1'b0;
      pdQ    <= 1'b0;
      idlQ   <= 1'b0;
    end else begin
      if (strobe.swWrite) begin
        baudQ  <= wrData[BIT_BAUD];
        frameQ <= wrData[BIT_FRAME];
        pofQ   <= wrData[BIT_POF];
        gf1Q   <= wrData[BIT_GF1];
        gf0Q   <= wrData[BIT_GF0];
        pdQ    <= wrData[BIT_PD];
        idlQ   <= wrData[BIT_IDL];
      end
      if (strobe.irqClear) idlQ <= 1'b0;
    end
  end

  always_comb begin
    regVal            = '0;
    regVal[BIT_BAUD]  = baudQ;
    regVal[BIT_FRAME] = frameQ;
    regVal[BIT_RSV]   = 1'b0;
    regVal[BIT_POF]   = pofQ;
    regVal[BIT_GF1]   = gf1Q;
    regVal[BIT_GF0]   = gf0Q;
    regVal[BIT_PD]    = pdQ;
    regVal[BIT_IDL]   = idlQ;
  end

  assert_cold_value_R3: assert property (@(posedge clk)
    strobe.porLoad |=> (regVal == COLD_VALUE));

  assert_warm_keeps_flag_R4: assert property (@(posedge clk) disable iff (strobe.porLoad)
    strobe.warmLoad |=> (regVal == ($past(regVal) & COLD_VALUE)));

  assert_irq_clears_idle_R7: assert property (@(posedge clk)
    disable iff (strobe.porLoad || strobe.warmLoad)
    strobe.irqClear |=> !regVal[BIT_IDL]);

  assert_hold_when_quiet_R1: assert property (@(posedge clk)
    disable iff (strobe.porLoad || strobe.warmLoad)
    (!strobe.swWrite && !strobe.irqClear) |=> $stable(regVal));

  assert_write_stores_R2: assert property (@(posedge clk)
    disable iff (strobe.porLoad || strobe.warmLoad)
    (strobe.swWrite && !strobe.irqClear) |=>
      (regVal == ($past(wrData) & ~(DATA_W'(1) << BIT_RSV))));
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              warmRst,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic              irqPending,
  output logic              idleMode,
  output logic              pdMode,
  output logic              baudDouble,
  output logic              frameSel
);
  pwrStrobe_t        strobe;
  logic              addrHit;
  logic [DATA_W-1:0] regVal;

  pwr_mode_ctrl #(.REG_ADDR(REG_ADDR)) u_ctrl (
    .clk        (clk),
    .porRst     (porRst),
    .warmRst    (warmRst),
    .sfrAddr    (sfrAddr),
    .sfrWe      (sfrWe),
    .irqPending (irqPending),
    .addrHit    (addrHit),
    .strobe     (strobe)
  );

  pwr_mode_regs u_regs (
    .clk    (clk),
    .strobe (strobe),
    .wrData (sfrWdata),
    .regVal (regVal)
  );

  always_comb begin
    sfrRdata   = addrHit ? regVal : '0;
    idleMode   = regVal[BIT_IDL];
    pdMode     = regVal[BIT_PD];
    baudDouble = regVal[BIT_BAUD];
    frameSel   = regVal[BIT_FRAME];
  end
endmodule

// File: tb/pwr_mode_reg_test.sv
module pwr_mode_reg_test;
  logic       clk = 1'b0;
  logic       porRst = 1'b0, warmRst = 1'b0, sfrWe = 1'b0, irqPending = 1'b0;
  logic [7:0] sfrAddr = 8'h00, sfrWdata = 8'h00;
  logic [7:0] sfrRdata;
  logic       idleMode, pdMode, baudDouble, frameSel;
  int         checks = 0, fails = 0;
  bit         done = 0;
  localparam logic [7:0] RA = 8'h87;

  always #2.5 clk = ~clk;

  pwr_mode_reg uut (
    .clk(clk), .porRst(porRst), .warmRst(warmRst), .sfrAddr(sfrAddr),
    .sfrWe(sfrWe), .sfrWdata(sfrWdata), .sfrRdata(sfrRdata),
    .irqPending(irqPending), .idleMode(idleMode), .pdMode(pdMode),
    .baudDouble(baudDouble), .frameSel(frameSel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one rising edge with the given controls, back to idle at the next falling edge
  task automatic cycle(input logic por, input logic warm, input logic we,
                       input logic [7:0] a, input logic [7:0] d, input logic irq);
    @(negedge clk);
    porRst = por; warmRst = warm; sfrWe = we; sfrAddr = a; sfrWdata = d; irqPending = irq;
    @(negedge clk);
    porRst = 0; warmRst = 0; sfrWe = 0; irqPending = 0;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] v);
    sfrAddr = a; #1; v = sfrRdata;
  endtask

  task automatic expectReg(input string req, input logic [7:0] exp);
    logic [7:0] v;
    readAt(RA, v);
    check(req, v, exp);
    check({req, "_R9"}, {baudDouble, frameSel, 4'b0, pdMode, idleMode},
          {exp[7], exp[6], 4'b0, exp[1], exp[0]});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    cycle(1, 0, 0, 8'h00, 8'h00, 0);
    expectReg("R3", 8'h10);

    // full byte sweep through the write path
    for (int i = 0; i < 256; i++) begin
      cycle(0, 0, 1, RA, 8'(i), 0);
      expectReg("R2_R6", 8'(i) & 8'hDF);
    end
    cycle(0, 0, 1, RA, 8'h10, 0); expectReg("R5_set", 8'h10);
    cycle(0, 0, 1, RA, 8'h00, 0); expectReg("R5_clear", 8'h00);

    // every other address is ignored
    cycle(0, 0, 1, RA, 8'h5A, 0);
    for (int a = 0; a < 256; a++) begin
      if (8'(a) != RA) begin
        cycle(0, 0, 1, 8'(a), 8'hA5, 0);
        readAt(8'(a), v); check("R1_miss_read", v, 8'h00);
        readAt(RA, v);    check("R1_unchanged", v, 8'h5A);
      end
    end

    // warm reset keeps the flag in both states
    cycle(0, 0, 1, RA, 8'hFF, 0); expectReg("R6", 8'hDF);
    cycle(0, 1, 0, RA, 8'h00, 0); expectReg("R4_flag1", 8'h10);
    cycle(0, 0, 1, RA, 8'hCF, 0); expectReg("R2", 8'hCF);
    cycle(0, 1, 0, RA, 8'h00, 0); expectReg("R4_flag0", 8'h00);

    // interrupt clears idle only
    cycle(0, 0, 1, RA, 8'h8D, 0); expectReg("R2", 8'h8D);
    cycle(0, 0, 0, RA, 8'h00, 1); expectReg("R7_clear", 8'h8C);
    cycle(0, 0, 0, RA, 8'h00, 1); expectReg("R7_noop", 8'h8C);
    cycle(0, 0, 1, RA, 8'h53, 1); expectReg("R8", 8'h52);

    // reset precedence
    cycle(0, 0, 1, RA, 8'h00, 0);
    cycle(0, 1, 1, RA, 8'hFF, 0); expectReg("R10_warm_over_write", 8'h00);
    cycle(1, 0, 1, RA, 8'h00, 0); expectReg("R10_por_over_write", 8'h10);
    cycle(0, 0, 1, RA, 8'hCB, 0);
    cycle(1, 1, 0, RA, 8'h00, 0); expectReg("R10_por_over_warm", 8'h10);
    finishRun();
  end
endmodule